// File: doc/BRIEF.md
# DAC Status Readback Controller

This block keeps a software-visible 32-bit copy of the internal status word of one external DAC device and decides when that copy is refreshed. Software starts a refresh by writing a one to the request bit. The block then:

- marks the copy as stale by dropping its valid flag;
- raises a level request toward a downstream serial engine;
- waits for the engine to acknowledge with the device's 10-bit status word;
- stores that word in the register and marks the copy valid again.

An automatic mode can also start a refresh each time a conversion-done strobe arrives. The serial protocol and the analog device lie outside this block.

At most one transfer is outstanding at any time. Further requests that arrive while a transfer is outstanding join that transfer. Software can clear the valid flag at any time by writing a one to it. Only a completed transfer sets the flag again. The status fields cannot be written by software.

Top module: `dac_stat_ctrl`

## Requirements
- R1: After reset the register reads 0x0000_0000 and `eng_req` is low.
- R2: A write with bit 31 set raises `eng_req` on the next cycle and clears the valid flag (bit 30) on the next cycle. Bit 31 always reads 0.
- R3: `eng_req` stays high on every cycle until a cycle in which `eng_ack` is high.
- R4: In a cycle with `eng_req` and `eng_ack` both high, `eng_data[9:0]` is stored into register bits 9:0 and bit 30 is set. The stored bits are: bit 9 thermal shutdown, bits 8:5 over-current for channels D, C, B, A, bit 4 reference powered up, bits 3:0 powered up for channels D, C, B, A. On the next cycle `eng_req` is low.
- R5: A write with bit 30 set clears the valid flag. A write with bit 30 clear leaves the flag unchanged.
- R6: Bit 28 is a read/write auto-mode enable. When bit 28 is 1, a `conv_done` pulse starts a status read exactly as a bit-31 request does. When bit 28 is 0, `conv_done` has no effect.
- R7: Bits 29 and 27:10 read 0. Writes to bits 29, 27:0 other than bit 28 change nothing and start no transfer.
- R8: A request while `eng_req` is high joins the outstanding transfer. It still clears the valid flag, and once the acknowledge arrives no second transfer follows.
- R9: If the valid flag is cleared by a write while a transfer is outstanding, the completion of that transfer sets the flag again.
- R10: A software request and an auto-mode `conv_done` in the same cycle produce a single transfer.
- R11: `eng_ack` while `eng_req` is low is ignored: bits 9:0 and the valid flag keep their values.
- R12: A request in the same cycle as a completing acknowledge joins that transfer. Afterwards the flag is set and `eng_req` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Register read value (from registers only) |
| conv_done | input | 1 | One-cycle conversion-done strobe |
| eng_req | output | 1 | Status read request to the serial engine, held until acknowledged |
| eng_ack | input | 1 | Serial engine acknowledge, with data valid |
| eng_data | input | 10 | Device status word returned with `eng_ack` |

## Verification
Every result in this block lands one clock edge after its stimulus: a write, strobe or acknowledge sampled on edge k shows up in `eng_req` and `rdata` straight after edge k. The bench drives inputs on falling edges. On the next falling edge it first samples the outputs and only then applies the next stimulus, so each check lands on the first cycle where its result is due. The capture path is swept over all 1024 status words. Merge and same-cycle cases are each checked for a request staying low over several cycles after the completion.

// File: rtl/dac_stat_pkg.sv
// Package: shared constants and field layout for the DAC status controller.
// Assumes one device with NCH analog channels and a 10-bit returned word.
package dac_stat_pkg;
    localparam int REG_W     = 32;
    localparam int NCH       = 4;
    localparam int STAT_W    = 2 * NCH + 2;
    localparam int BIT_REQ   = 31;
    localparam int BIT_VALID = 30;
    localparam int BIT_AUTO  = 28;
    localparam int PU_LSB    = 0;
    localparam int REF_BIT   = NCH;
    localparam int OC_LSB    = NCH + 1;
    localparam int TSD_BIT   = 2 * NCH + 1;

    // Captured device status, most significant field first.
    typedef struct packed {
        logic           tsd;
        logic [NCH-1:0] oc;
        logic           refup;
        logic [NCH-1:0] pu;
    } stat_t;
endpackage

// File: rtl/dac_stat_trig.sv
// Module: request source decode. Turns register writes and conversion strobes
// into a single trigger pulse and a clear pulse, and holds the auto-mode bit.
// Assumes wr_en and conv_done are single-cycle strobes in the clk domain.
module dac_stat_trig
    import dac_stat_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    input  logic             conv_done,
    output logic             trig,
    output logic             clr_valid,
    output logic             auto_en
);
    logic sw_req;
    logic hw_req;

    // Auto-mode enable register, software read/write.
    always_ff @(posedge clk) begin
        if (!rst_n)      auto_en <= 1'b0;
        else if (wr_en)  auto_en <= wdata[BIT_AUTO];
    end

    // Merge both request sources into one pulse; they can never double up.
    always_comb begin
        sw_req    = wr_en & wdata[BIT_REQ];
        hw_req    = conv_done & auto_en;
        trig      = sw_req | hw_req;
        clr_valid = wr_en & wdata[BIT_VALID];
    end

    assert_auto_trig_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && auto_en) |-> trig);
    assert_manual_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!auto_en && !(wr_en && wdata[BIT_REQ])) |-> !trig);
endmodule

// File: rtl/dac_stat_sched.sv
// Module: transfer scheduler and valid flag. Keeps at most one transfer
// outstanding, merges late requests into it, and owns the valid bit.
// Assumes the engine asserts ack for one cycle, only while req is high.
module dac_stat_sched (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    input  logic clr_valid,
    input  logic eng_ack,
    output logic eng_req,
    output logic done,
    output logic valid
);
    // Completion is an ack seen while a transfer is outstanding.
    always_comb done = eng_req & eng_ack;

    // Request level: raised by a trigger, dropped by completion, merges in between.
    always_ff @(posedge clk) begin
        if (!rst_n)     eng_req <= 1'b0;
        else if (done)  eng_req <= 1'b0;
        else if (trig)  eng_req <= 1'b1;
    end

    // Valid flag: completion wins over request or clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                  valid <= 1'b0;
        else if (done)               valid <= 1'b1;
        else if (trig || clr_valid)  valid <= 1'b0;
    end

    assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && !eng_ack) |=> eng_req);
    assert_done_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (valid && !eng_req));
    assert_trig_starts_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && !done) |=> (eng_req && !valid));
    assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_valid && !done) |=> !valid);
    assert_rise_only_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid && !done) |=> !valid);
endmodule

// File: rtl/dac_stat_store.sv
// Module: status field store. Loads the device word into per-channel alert and
// power flags on completion; otherwise holds. Software cannot write it.
// Assumes the word layout given in dac_stat_pkg.
module dac_stat_store
    import dac_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  logic [STAT_W-1:0] eng_data,
    output stat_t             stat
);
    // Per-channel over-current and power-up flags.
    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        // Load this channel's pair of flags on completion.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stat.oc[ch] <= 1'b0;
                stat.pu[ch] <= 1'b0;
            end else if (done) begin
                stat.oc[ch] <= eng_data[OC_LSB + ch];
                stat.pu[ch] <= eng_data[PU_LSB + ch];
            end
        end
    end

    // Device-wide thermal and reference flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat.tsd   <= 1'b0;
            stat.refup <= 1'b0;
        end else if (done) begin
            stat.tsd   <= eng_data[TSD_BIT];
            stat.refup <= eng_data[REF_BIT];
        end
    end

    assert_hold_no_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> $stable(stat));
    assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (stat == $past(eng_data)));
endmodule

// File: rtl/dac_stat_ctrl.sv
// Module: top of the DAC status readback controller. Wires request decode,
// scheduler and field store, and assembles the 32-bit read value.
// Assumes rdata is sampled combinationally from registers only.
module dac_stat_ctrl
    import dac_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    input  logic              conv_done,
    output logic              eng_req,
    input  logic              eng_ack,
    input  logic [STAT_W-1:0] eng_data
);
    logic  trig;
    logic  clr_valid;
    logic  auto_en;
    logic  done;
    logic  valid;
    stat_t stat;

    dac_stat_trig u_trig (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata),
        .conv_done(conv_done), .trig(trig), .clr_valid(clr_valid),
        .auto_en(auto_en)
    );

    dac_stat_sched u_sched (
        .clk(clk), .rst_n(rst_n), .trig(trig), .clr_valid(clr_valid),
        .eng_ack(eng_ack), .eng_req(eng_req), .done(done), .valid(valid)
    );

    dac_stat_store u_store (
        .clk(clk), .rst_n(rst_n), .done(done), .eng_data(eng_data),
        .stat(stat)
    );

    // Read value: request bit and reserved bits are zero.
    always_comb begin
        rdata               = '0;
        rdata[BIT_VALID]    = valid;
        rdata[BIT_AUTO]     = auto_en;
        rdata[STAT_W-1:0]   = stat;
    end

    assert_req_drop_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && eng_ack) |=> !eng_req);
    assert_merge_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && !eng_ack && trig) |=> (eng_req && !rdata[BIT_VALID]));
endmodule

// File: tb/dac_stat_ctrl_test.sv
module dac_stat_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        conv_done = 1'b0;
    logic        eng_req;
    logic        eng_ack = 1'b0;
    logic [9:0]  eng_data = '0;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    dac_stat_ctrl uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
        .conv_done(conv_done), .eng_req(eng_req), .eng_ack(eng_ack),
        .eng_data(eng_data)
    );

    function automatic logic [31:0] expv(logic v, logic a, logic [9:0] s);
        return {1'b0, v, 1'b0, a, 18'b0, s};
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic nxt();
        @(negedge clk);
        wr_en = 1'b0; conv_done = 1'b0; eng_ack = 1'b0;
    endtask

    task automatic wr(logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wdata = d; conv_done = 1'b0; eng_ack = 1'b0;
        nxt();
    endtask

    task automatic ack(logic [9:0] d);
        @(negedge clk);
        eng_ack = 1'b1; eng_data = d; wr_en = 1'b0; conv_done = 1'b0;
        nxt();
    endtask

    logic [9:0] cur;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 rdata", rdata, 32'h0);
        chk("R1 req", {31'b0, eng_req}, 32'h0);

        // R3: request held while no acknowledge
        wr(32'h8000_0000);
        chk("R2 req up", {31'b0, eng_req}, 32'h1);
        chk("R2 read", rdata, expv(0, 0, 10'h0));
        for (int i = 0; i < 5; i++) begin
            nxt();
            chk("R3 hold", {31'b0, eng_req}, 32'h1);
        end
        ack(10'h000);
        chk("R4 req low", {31'b0, eng_req}, 32'h0);

        // R4 exhaustive capture sweep
        cur = 10'h000;
        for (int v = 0; v < 1024; v++) begin
            wr(32'h8000_0000);
            chk("R2 req", {31'b0, eng_req}, 32'h1);
            chk("R2 stale", rdata, expv(0, 0, cur));
            ack(v[9:0]);
            cur = v[9:0];
            chk("R4 capture", rdata, expv(1, 0, cur));
            chk("R4 req drop", {31'b0, eng_req}, 32'h0);
        end

        // R5: write one clears valid, write zero keeps
        wr(32'h0000_0000);
        chk("R5 zero keeps", rdata, expv(1, 0, cur));
        wr(32'h4000_0000);
        chk("R5 w1c", rdata, expv(0, 0, cur));
        chk("R5 no req", {31'b0, eng_req}, 32'h0);

        // R7: reserved and read-only bits ignore writes
        wr(32'h2FFF_FFFF);
        chk("R7 ignored", rdata, expv(0, 0, cur));
        nxt();
        chk("R7 no req", {31'b0, eng_req}, 32'h0);

        // R6: auto mode off, conv_done ignored
        @(negedge clk); conv_done = 1'b1;
        nxt();
        chk("R6 off no req", {31'b0, eng_req}, 32'h0);
        wr(32'h1000_0000);
        chk("R6 auto read", rdata, expv(0, 1, cur));
        @(negedge clk); conv_done = 1'b1;
        nxt();
        chk("R6 auto req", {31'b0, eng_req}, 32'h1);
        ack(10'h155);
        cur = 10'h155;
        chk("R6 auto done", rdata, expv(1, 1, cur));

        // R10: software request and auto strobe together -> one transfer
        @(negedge clk); wr_en = 1'b1; wdata = 32'h9000_0000; conv_done = 1'b1;
        nxt();
        chk("R10 req", {31'b0, eng_req}, 32'h1);
        ack(10'h2AA);
        cur = 10'h2AA;
        chk("R10 done", rdata, expv(1, 1, cur));
        for (int i = 0; i < 3; i++) begin
            nxt();
            chk("R10 single", {31'b0, eng_req}, 32'h0);
        end
        wr(32'h0000_0000);
        chk("R6 auto off", rdata, expv(1, 0, cur));

        // R8: request while in flight merges
        wr(32'h8000_0000);
        ack(10'h0F0);
        cur = 10'h0F0;
        wr(32'h8000_0000);
        wr(32'h4000_0000);
        wr(32'h8000_0000);
        chk("R8 still clear", rdata, expv(0, 0, cur));
        chk("R8 one req", {31'b0, eng_req}, 32'h1);
        ack(10'h30F);
        cur = 10'h30F;
        chk("R8 done", rdata, expv(1, 0, cur));
        for (int i = 0; i < 3; i++) begin
            nxt();
            chk("R8 no second", {31'b0, eng_req}, 32'h0);
        end

        // R9: clear during flight, completion sets again
        wr(32'h8000_0000);
        wr(32'h4000_0000);
        chk("R9 cleared", rdata, expv(0, 0, cur));
        ack(10'h3C3);
        cur = 10'h3C3;
        chk("R9 set again", rdata, expv(1, 0, cur));

        // R11: stray acknowledge ignored
        ack(10'h011);
        chk("R11 ignored", rdata, expv(1, 0, cur));
        wr(32'h4000_0000);
        ack(10'h022);
        chk("R11 valid stays", rdata, expv(0, 0, cur));

        // R12: request in the acknowledge cycle joins it
        wr(32'h8000_0000);
        @(negedge clk);
        eng_ack = 1'b1; eng_data = 10'h1E1; wr_en = 1'b1; wdata = 32'h8000_0000;
        nxt();
        cur = 10'h1E1;
        chk("R12 valid", rdata, expv(1, 0, cur));
        for (int i = 0; i < 3; i++) begin
            nxt();
            chk("R12 no req", {31'b0, eng_req}, 32'h0);
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule